// File: doc/BRIEF.md
# Receive Descriptor Ring Buffer Manager

This block decides where each incoming Ethernet frame lands in memory. Software builds a ring of two-word receive descriptors in a word-addressed memory. Each descriptor holds a buffer address, an ownership flag and a wrap flag, followed by a status word. When a frame starts, the block reads the descriptor at its ring pointer. If software still owns that buffer, the frame is thrown away and counted. Otherwise the bytes are packed into 32-bit words and written to the buffer. The length goes into the status word, the ownership flag is set, and the ring pointer moves on.

Frame bytes arrive on a valid/ready stream that carries start, end and error markers. A byte moves only in a cycle where both `rx_valid` and `rx_ready` are high, and the source must hold the byte and its markers steady until then. The block lowers `rx_ready` in these cases: while it waits for a descriptor, while a memory access is pending, and while it is closing out a finished frame. Memory traffic uses a request/grant port. A grant that comes too late, or an error response, counts as an overrun. After an overrun the buffer is not consumed, and the next frame goes into the same buffer. An optional mode keeps the four trailing FCS bytes out of memory and out of the reported length.

Top module: `rxd_buf_mgr`

## Requirements
- R1: After reset `mem_req`, all three interrupt outputs and `rsrc_err_cnt` are zero.
- R2: When a frame starts, the block reads the descriptor word at the ring pointer. If bit 0 of that word is clear, the frame's bytes go into consecutive words from the buffer word address held in bits [AW+1:2]. Bytes are packed little-endian (first byte in bits [7:0]), and the unused upper bytes of a final partial word are written as zero.
- R3: After a frame is stored, the byte count is written to the status word at pointer+1. The descriptor word is then written back with bit 0 set and its other bits kept, and `irq_frame_done` pulses.
- R4: If bit 0 of the fetched descriptor is already set, `irq_no_buf` pulses and `rsrc_err_cnt` increments. The frame is drained with no write to the buffer or the descriptor, and the ring pointer does not move.
- R5: After a stored frame whose descriptor has bit 1 clear, the ring pointer advances by two words.
- R6: After a stored frame whose descriptor has bit 1 set, the ring pointer returns to `cfg_ring_base`.
- R7: With `cfg_strip_fcs` high, the last four bytes of a frame are not written to memory, and the reported length is four less than the number of bytes received.
- R8: An error response on a granted access pulses `irq_overrun`. The rest of the frame is dropped, the descriptor is not marked, and the next frame reuses the same buffer.
- R9: A request that is still without a grant after MAX_WAIT waiting cycles is treated as an overrun, with the same effects as R8.
- R10: A frame whose final byte carries `rx_err` is discarded. Its descriptor and status word are left untouched, no interrupt is raised, and the pointer stays put.
- R11: While `cfg_rx_en` is low the ring pointer is reloaded from `cfg_ring_base`, any frame in progress is abandoned, and no memory request is made from the next cycle on.
- R12: `rx_ready` is low in every cycle `mem_req` is high. Address, direction and write data stay stable until the request is granted or times out. A frame stored with a slow but in-time grant is identical to one stored with an immediate grant.
- R13: Each interrupt is a one-cycle pulse, and no two interrupts are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_en | input | 1 | Receive enable; low resets the ring pointer |
| cfg_strip_fcs | input | 1 | Keep the four FCS bytes out of memory and length |
| cfg_ring_base | input | AW | Word address of the first descriptor |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Stream byte accepted when high with rx_valid |
| rx_data | input | 8 | Stream byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Frame is bad (sampled with rx_eof) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| mem_gnt | input | 1 | Access completes this cycle |
| mem_err | input | 1 | Error response, sampled with mem_gnt |
| irq_frame_done | output | 1 | Pulse: frame stored |
| irq_no_buf | output | 1 | Pulse: descriptor still owned by software |
| irq_overrun | output | 1 | Pulse: memory access failed or was late |
| rsrc_err_cnt | output | CW | Frames dropped for lack of a buffer |

## Verification
The storage path is driven with frames of 10, 9, 7, 6, 5, 4 and 3 bytes, so the final word lands at every fill level. This catches byte-lane and zero-fill faults that a word-aligned length would hide. Running the same frame length with FCS stripping on and off separates the holdback logic from the length arithmetic, and a three-descriptor ring with a wrap flag separates stepping from wrapping. Each failure path is followed by a clean frame: a still-owned buffer, an error response mid-frame, a grant timeout during fetch, and a bad-frame marker. Where that clean frame lands shows whether the pointer moved. A grant delayed by three cycles, set beside the immediate grant, shows that back-pressure alters timing only and never the stored data.

// File: rtl/rxd_pkg.sv
`timescale 1ns/1ps
package rxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_RECV, S_WDATA, S_WSTAT, S_WDESC, S_DROP
  } rxd_state_e;

  localparam int OWN_BIT  = 0;
  localparam int WRAP_BIT = 1;
endpackage

// File: rtl/rxd_byte_pack.sv
`timescale 1ns/1ps
module rxd_byte_pack #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [7:0]    byte_in,
  input  logic          strip,
  input  logic          drain,
  output logic [31:0]   word_o,
  output logic          full_o,
  output logic          any_o,
  output logic [LW-1:0] len_o
);
  localparam int HOLD = 4;

  logic [7:0]    hold [HOLD];
  logic [2:0]    hcnt;
  logic [2:0]    bcnt;
  logic [31:0]   wbuf;
  logic [LW-1:0] tot;
  logic          emit;
  logic [7:0]    ebyte;

  always_comb begin
    emit  = take && (!strip || hcnt == 3'(HOLD));
    ebyte = strip ? hold[0] : byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      bcnt <= '0;
      wbuf <= '0;
      tot  <= '0;
      for (int i = 0; i < HOLD; i++) hold[i] <= '0;
    end else if (clr) begin
      hcnt <= '0;
      bcnt <= '0;
      wbuf <= '0;
      tot  <= '0;
    end else begin
      if (take) tot <= tot + LW'(1);
      if (take && strip) begin
        if (hcnt == 3'(HOLD)) begin
          for (int i = 0; i < HOLD-1; i++) hold[i] <= hold[i+1];
          hold[HOLD-1] <= byte_in;
        end else begin
          hold[hcnt[1:0]] <= byte_in;
          hcnt <= hcnt + 3'd1;
        end
      end
      if (drain) begin
        bcnt <= '0;
        wbuf <= '0;
      end else if (emit) begin
        wbuf[bcnt[1:0]*8 +: 8] <= ebyte;
        bcnt <= bcnt + 3'd1;
      end
    end
  end

  assign word_o = wbuf;
  assign full_o = (bcnt == 3'd4);
  assign any_o  = (bcnt != 3'd0);
  assign len_o  = !strip ? tot : ((tot >= LW'(4)) ? tot - LW'(4) : '0);
endmodule

// File: rtl/rxd_mem_port.sv
`timescale 1ns/1ps
module rxd_mem_port #(
  parameter int MAX_WAIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic gnt,
  input  logic err,
  output logic ok,
  output logic ovr
);
  localparam int WW = $clog2(MAX_WAIT + 1) + 1;

  logic [WW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            wcnt <= '0;
    else if (req && !gnt)  wcnt <= wcnt + WW'(1);
    else                   wcnt <= '0;
  end

  assign ok  = req && gnt && !err;
  assign ovr = req && ((gnt && err) || (!gnt && wcnt == WW'(MAX_WAIT)));
endmodule

// File: rtl/rxd_ring_ptr.sv
`timescale 1ns/1ps
module rxd_ring_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] base,
  input  logic          adv,
  input  logic          wrap,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr_o <= '0;
    else if (!en)  ptr_o <= base;
    else if (adv)  ptr_o <= wrap ? base : ptr_o + AW'(2);
  end
endmodule

// File: rtl/rxd_buf_mgr.sv
`timescale 1ns/1ps
module rxd_buf_mgr
  import rxd_pkg::*;
#(
  parameter int AW       = 16,
  parameter int LW       = 16,
  parameter int CW       = 16,
  parameter int MAX_WAIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_rx_en,
  input  logic          cfg_strip_fcs,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          rx_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_gnt,
  input  logic          mem_err,
  output logic          irq_frame_done,
  output logic          irq_no_buf,
  output logic          irq_overrun,
  output logic [CW-1:0] rsrc_err_cnt
);
  rxd_state_e    state;
  logic [31:0]   desc0;
  logic [AW-1:0] bufw;
  logic [AW-1:0] widx;
  logic          last;
  logic [AW-1:0] ptr;
  logic          acc, ok, ovr;
  logic          pk_full, pk_any;
  logic [31:0]   pk_word;
  logic [LW-1:0] pk_len;

  always_comb begin
    case (state)
      S_IDLE:  rx_ready = cfg_rx_en && rx_valid && !rx_sof;
      S_RECV:  rx_ready = !pk_full && !last;
      S_DROP:  rx_ready = 1'b1;
      default: rx_ready = 1'b0;
    endcase
    acc = rx_valid && rx_ready;
  end

  always_comb begin
    mem_req   = (state == S_FETCH) || (state == S_WDATA) ||
                (state == S_WSTAT) || (state == S_WDESC);
    mem_we    = (state != S_FETCH);
    mem_addr  = ptr;
    mem_wdata = '0;
    case (state)
      S_WDATA: begin mem_addr = bufw + widx;    mem_wdata = pk_word; end
      S_WSTAT: begin mem_addr = ptr + AW'(1);   mem_wdata = 32'(pk_len); end
      S_WDESC: mem_wdata = desc0 | (32'd1 << OWN_BIT);
      default: ;
    endcase
  end

  rxd_mem_port #(.MAX_WAIT(MAX_WAIT)) u_port (
    .clk(clk), .rst_n(rst_n), .req(mem_req), .gnt(mem_gnt), .err(mem_err),
    .ok(ok), .ovr(ovr)
  );

  rxd_byte_pack #(.LW(LW)) u_pack (
    .clk(clk), .rst_n(rst_n),
    .clr(state == S_FETCH),
    .take((state == S_RECV) && acc),
    .byte_in(rx_data),
    .strip(cfg_strip_fcs),
    .drain((state == S_WDATA) && ok),
    .word_o(pk_word), .full_o(pk_full), .any_o(pk_any), .len_o(pk_len)
  );

  rxd_ring_ptr #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .en(cfg_rx_en), .base(cfg_ring_base),
    .adv((state == S_WDESC) && ok && cfg_rx_en),
    .wrap(desc0[WRAP_BIT]),
    .ptr_o(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= S_IDLE;
      desc0          <= '0;
      bufw           <= '0;
      widx           <= '0;
      last           <= 1'b0;
      irq_frame_done <= 1'b0;
      irq_no_buf     <= 1'b0;
      irq_overrun    <= 1'b0;
      rsrc_err_cnt   <= '0;
    end else begin
      irq_frame_done <= 1'b0;
      irq_no_buf     <= 1'b0;
      irq_overrun    <= 1'b0;
      if (!cfg_rx_en) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (rx_valid && rx_sof) state <= S_FETCH;
          S_FETCH: begin
            if (ovr) begin
              irq_overrun <= 1'b1;
              state       <= S_DROP;
            end else if (ok) begin
              desc0 <= mem_rdata;
              if (mem_rdata[OWN_BIT]) begin
                irq_no_buf   <= 1'b1;
                rsrc_err_cnt <= rsrc_err_cnt + CW'(1);
                state        <= S_DROP;
              end else begin
                bufw  <= mem_rdata[AW+1:2];
                widx  <= '0;
                last  <= 1'b0;
                state <= S_RECV;
              end
            end
          end
          S_RECV: begin
            if (last)                  state <= (pk_full || pk_any) ? S_WDATA : S_WSTAT;
            else if (pk_full)          state <= S_WDATA;
            else if (acc && rx_eof) begin
              if (rx_err) state <= S_IDLE;
              else        last  <= 1'b1;
            end
          end
          S_WDATA: begin
            if (ovr) begin
              irq_overrun <= 1'b1;
              state       <= last ? S_IDLE : S_DROP;
            end else if (ok) begin
              widx  <= widx + AW'(1);
              state <= last ? S_WSTAT : S_RECV;
            end
          end
          S_WSTAT: begin
            if (ovr) begin
              irq_overrun <= 1'b1;
              state       <= S_IDLE;
            end else if (ok) state <= S_WDESC;
          end
          S_WDESC: begin
            if (ovr) begin
              irq_overrun <= 1'b1;
              state       <= S_IDLE;
            end else if (ok) begin
              irq_frame_done <= 1'b1;
              state          <= S_IDLE;
            end
          end
          S_DROP: if (acc && rx_eof) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxd_buf_mgr_chk.sv
`timescale 1ns/1ps
module rxd_buf_mgr_chk #(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int MAX_WAIT = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_rx_en,
  input logic          rx_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [31:0]   mem_wdata,
  input logic          mem_gnt,
  input logic          irq_frame_done,
  input logic          irq_no_buf,
  input logic          irq_overrun,
  input logic [CW-1:0] rsrc_err_cnt
);
  localparam int CWW = $clog2(MAX_WAIT + 2) + 2;
  logic [CWW-1:0] waited;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   waited <= '0;
    else if (mem_req && !mem_gnt) waited <= waited + CWW'(1);
    else                          waited <= '0;
  end

  // R11
  disabled_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rx_en |=> !mem_req);

  // R12
  stall_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !rx_ready);

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && cfg_rx_en && waited < CWW'(MAX_WAIT))
      |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R9
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> waited <= CWW'(MAX_WAIT));

  // R4
  cnt_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsrc_err_cnt != $past(rsrc_err_cnt)) |-> irq_no_buf);

  // R13
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_frame_done, irq_no_buf, irq_overrun}));

  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_frame_done |=> !irq_frame_done);

  // R3
  done_after_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_frame_done) |-> $past(mem_req && mem_we && mem_gnt && mem_wdata[0]));
endmodule

bind rxd_buf_mgr rxd_buf_mgr_chk #(.AW(AW), .CW(CW), .MAX_WAIT(MAX_WAIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .rx_ready(rx_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_gnt(mem_gnt), .irq_frame_done(irq_frame_done), .irq_no_buf(irq_no_buf),
  .irq_overrun(irq_overrun), .rsrc_err_cnt(rsrc_err_cnt)
);

// File: tb/rxd_buf_mgr_tb.sv
`timescale 1ns/1ps
module rxd_buf_mgr_tb;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam logic [31:0] SENT = 32'hDEADBEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_rx_en = 1'b0, cfg_strip_fcs = 1'b0;
  logic [AW-1:0] cfg_ring_base = 16'd16;
  logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready;
  logic mem_req, mem_we, mem_gnt, mem_err;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic irq_frame_done, irq_no_buf, irq_overrun;
  logic [CW-1:0] rsrc_err_cnt;

  logic [31:0] mem [256];
  int gnt_delay = 0;
  int bwait = 0;
  logic err_arm = 1'b0;
  int n_done = 0, n_nobuf = 0, n_ovr = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rxd_buf_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_rx_en(cfg_rx_en), .cfg_strip_fcs(cfg_strip_fcs),
    .cfg_ring_base(cfg_ring_base), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_gnt(mem_gnt), .mem_err(mem_err),
    .irq_frame_done(irq_frame_done), .irq_no_buf(irq_no_buf),
    .irq_overrun(irq_overrun), .rsrc_err_cnt(rsrc_err_cnt)
  );

  assign mem_gnt   = mem_req && (bwait >= gnt_delay);
  assign mem_err   = mem_gnt && mem_we && err_arm && (mem_addr >= 16'd64);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (mem_req && !mem_gnt) bwait <= bwait + 1; else bwait <= 0;
    if (mem_gnt && mem_err) err_arm <= 1'b0;
    if (mem_gnt && mem_we && !mem_err) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (irq_frame_done) n_done++;
    if (irq_no_buf) n_nobuf++;
    if (irq_overrun) n_ovr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xw(input logic [7:0] seed, input int k, input int n);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < n) w[8*j +: 8] = seed + 8'(4*k + j);
    return w;
  endfunction

  task automatic init_ring();
    for (int i = 0; i < 256; i++) mem[i] = SENT;
    mem[16] = 32'd64 << 2;  mem[17] = 0;
    mem[18] = 32'd96 << 2;  mem[19] = 0;
    mem[20] = (32'd128 << 2) | 32'd2; mem[21] = 0;
  endtask

  task automatic send(input logic [7:0] seed, input int n, input logic bad);
    n_done = 0; n_nobuf = 0; n_ovr = 0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_data = seed + 8'(i);
      rx_sof = (i == 0); rx_eof = (i == n-1); rx_err = bad && (i == n-1);
      #1;
      while (!rx_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", 32'(mem_req), 0);
    chk("R1 irqs", 32'({irq_frame_done, irq_no_buf, irq_overrun}), 0);
    chk("R1 cnt", 32'(rsrc_err_cnt), 0);
  endtask

  task automatic t_basic();
    send(8'h10, 10, 1'b0);
    for (int k = 0; k < 3; k++) chk("R2 data word", mem[64+k], xw(8'h10, k, 10));
    chk("R2 after buffer", mem[67], SENT);
    chk("R3 length", mem[17], 10);
    chk("R3 owned", mem[16], (32'd64 << 2) | 1);
    chk("R3 done irq", 32'(n_done), 1);
  endtask

  task automatic t_strip();
    cfg_strip_fcs = 1'b1;
    send(8'h40, 10, 1'b0);
    cfg_strip_fcs = 1'b0;
    chk("R5 next descriptor", mem[18], (32'd96 << 2) | 1);
    chk("R7 word0", mem[96], xw(8'h40, 0, 6));
    chk("R7 word1", mem[97], xw(8'h40, 1, 6));
    chk("R7 fcs not written", mem[98], SENT);
    chk("R7 length", mem[19], 6);
  endtask

  task automatic t_wrap_used();
    send(8'h70, 5, 1'b0);
    chk("R2 partial word", mem[129], xw(8'h70, 1, 5));
    chk("R3 wrap desc kept", mem[20], (32'd128 << 2) | 3);
    send(8'hA0, 6, 1'b0);
    chk("R4 no_buf irq", 32'(n_nobuf), 1);
    chk("R4 counter", 32'(rsrc_err_cnt), 1);
    chk("R4 no done", 32'(n_done), 0);
    chk("R4 buffer intact", mem[64], xw(8'h10, 0, 10));
    chk("R4 status intact", mem[17], 10);
    mem[16] = 32'd64 << 2;
    send(8'hC0, 4, 1'b0);
    chk("R6 wrapped to base", mem[64], xw(8'hC0, 0, 4));
    chk("R4 pointer held", mem[17], 4);
  endtask

  task automatic t_bad_frame();
    init_ring();
    send(8'h30, 7, 1'b1);
    chk("R10 no irq", 32'(n_done + n_nobuf + n_ovr), 0);
    chk("R10 desc intact", mem[18], 32'd96 << 2);
    chk("R10 status intact", mem[19], 0);
    send(8'h33, 3, 1'b0);
    chk("R10 same desc reused", mem[19], 3);
    chk("R10 reuse data", mem[96], xw(8'h33, 0, 3));
  endtask

  task automatic t_overrun_err();
    err_arm = 1'b1;
    send(8'h50, 10, 1'b0);
    chk("R8 overrun irq", 32'(n_ovr), 1);
    chk("R8 no done", 32'(n_done), 0);
    chk("R8 desc not marked", mem[20], (32'd128 << 2) | 2);
    chk("R8 status intact", mem[21], 0);
    send(8'h60, 6, 1'b0);
    chk("R8 buffer reused", mem[128], xw(8'h60, 0, 6));
    chk("R8 reused length", mem[21], 6);
  endtask

  task automatic t_timeout();
    init_ring();
    gnt_delay = 20;
    send(8'h80, 5, 1'b0);
    gnt_delay = 0;
    chk("R9 overrun irq", 32'(n_ovr), 1);
    chk("R9 desc intact", mem[16], 32'd64 << 2);
    send(8'h90, 5, 1'b0);
    chk("R9 buffer reused", mem[17], 5);
    chk("R9 data", mem[65], xw(8'h90, 1, 5));
  endtask

  task automatic t_stall();
    gnt_delay = 3;
    send(8'h11, 9, 1'b0);
    gnt_delay = 0;
    for (int k = 0; k < 3; k++) chk("R12 stalled data", mem[96+k], xw(8'h11, k, 9));
    chk("R12 length", mem[19], 9);
    chk("R12 no overrun", 32'(n_ovr), 0);
  endtask

  task automatic t_disable();
    init_ring();
    @(negedge clk); cfg_rx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 no request", 32'(mem_req), 0);
    cfg_rx_en = 1'b1;
    send(8'h22, 4, 1'b0);
    chk("R11 pointer at base", mem[17], 4);
    chk("R11 old slot untouched", mem[21], 0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    init_ring();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_rx_en = 1'b1;
    @(negedge clk);
    t_basic();
    t_strip();
    t_wrap_used();
    t_bad_frame();
    t_overrun_err();
    t_timeout();
    t_stall();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule